// File: doc/BRIEF.md
# Interrupt Request Front End

This block sits between the interrupt line shared by peripheral devices and the next-address logic of a single-cycle processor. The device request arrives with no relation to the processor clock. It passes through a chain of synchronizing flops before any decision is made on it. When the synchronized request is high and interrupts are not masked, the block takes the interrupt. Taking it does four things: it acknowledges the device, it masks any further request, it raises a one-cycle alert, and it steers the next program counter to a fixed handler address. In that same cycle it keeps the current program counter as the return address.

Software controls the mask with two single-cycle strobes. One enables interrupts by clearing the mask, and one disables them by setting it. The acknowledge stays high until the synchronized request falls, so the device has a clean handshake for dropping its line. No second interrupt is taken from the same request.

Top module: `irq_front`

## Requirements
- R1: The device request passes through SYNC_STAGES flops (default 2) before it can be taken. A request that is high at clock edge k can raise `irq_alert` no earlier than the cycle that follows edge k+SYNC_STAGES-1.
- R2: A request is never taken while `irq_masked` is 1. The request is held masked with `irq_alert` at 0 and `irq_ack` at 0.
- R3: `irq_ack` rises on the clock edge that ends the alert cycle and stays at 1 while the synchronized request is 1. It returns to 0 on the first edge at which the synchronized request is 0. No request is taken while `irq_ack` is 1.
- R4: `irq_alert` is 1 for exactly one cycle for each interrupt taken, and is combinational in that cycle.
- R5: Taking an interrupt sets `irq_masked` to 1 on the edge that ends the alert cycle.
- R6: A cycle with `irq_en_stb`=1 clears the mask at the next edge. A cycle with `irq_dis_stb`=1 sets it. When both are 1 in the same cycle, the mask ends at 1.
- R7: After reset, `irq_masked` is 1, `irq_ack` is 0, `irq_alert` is 0 and `pc_saved` is 0.
- R8: `pc_next` equals HANDLER_PC while `irq_alert` is 1. Otherwise it equals `pc_seq`.
- R9: On the edge that ends an alert cycle, `pc_saved` loads the `pc_cur` value of that cycle. At all other times it holds its value.
- R10: If an interrupt is taken in a cycle that also carries `irq_en_stb`, the mask still ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_async | input | 1 | Device interrupt request, asynchronous |
| irq_en_stb | input | 1 | Strobe that clears the mask |
| irq_dis_stb | input | 1 | Strobe that sets the mask |
| pc_seq | input | PC_W | Sequential next PC from the rest of the next-address logic |
| pc_cur | input | PC_W | Current PC, kept as the return address |
| irq_ack | output | 1 | Acknowledge to the device |
| irq_masked | output | 1 | Current mask state |
| irq_alert | output | 1 | Interrupt-taken pulse to the next-address logic |
| pc_next | output | PC_W | Selected next PC |
| pc_saved | output | PC_W | Return address captured when an interrupt is taken |

## Verification
Taking an interrupt and a software mask strobe can fall in the same cycle, and both update the one mask flop. The bench clears the mask, raises the request, and drives an enable or a disable strobe in exactly the cycle where the alert is expected. The result is judged by the behavioural model: acceptance forces the mask to 1 whichever strobe is present. The next request must then stay unserved until a later enable.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;

  // Next mask state: taking an interrupt or a disable strobe sets it,
  // an enable strobe clears it, otherwise hold.
  function automatic logic mask_step(logic cur, logic take, logic en, logic dis);
    if (take || dis) return 1'b1;
    if (en)          return 1'b0;
    return cur;
  endfunction

  // Next acknowledge state: set on take, dropped once the synchronized
  // request is low, otherwise hold.
  function automatic logic ack_step(logic cur, logic take, logic req_s);
    if (take)   return 1'b1;
    if (!req_s) return 1'b0;
    return cur;
  endfunction

  // Acceptance condition.
  function automatic logic take_ok(logic req_s, logic mask, logic ack);
    return req_s && !mask && !ack;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_front_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic en_stb,
  input  logic dis_stb,
  output logic ack,
  output logic mask,
  output logic take
);
  assign take = take_ok(req_s, mask, ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack  <= 1'b0;
      mask <= 1'b1;
    end else begin
      ack  <= ack_step(ack, take, req_s);
      mask <= mask_step(mask, take, en_stb, dis_stb);
    end
  end
endmodule

// File: rtl/irq_pcsel.sv
module irq_pcsel #(
  parameter int              PC_W       = 30,
  parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [PC_W-1:0] pc_seq,
  input  logic [PC_W-1:0] pc_cur,
  output logic [PC_W-1:0] pc_next,
  output logic [PC_W-1:0] pc_saved
);
  assign pc_next = take ? HANDLER_PC : pc_seq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_saved <= '0;
    else if (take) pc_saved <= pc_cur;
  end
endmodule

// File: rtl/irq_front.sv
module irq_front #(
  parameter int              PC_W        = 30,
  parameter int              SYNC_STAGES = 2,
  parameter logic [PC_W-1:0] HANDLER_PC  = PC_W'(32'h0000_0100)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req_async,
  input  logic            irq_en_stb,
  input  logic            irq_dis_stb,
  input  logic [PC_W-1:0] pc_seq,
  input  logic [PC_W-1:0] pc_cur,
  output logic            irq_ack,
  output logic            irq_masked,
  output logic            irq_alert,
  output logic [PC_W-1:0] pc_next,
  output logic [PC_W-1:0] pc_saved
);
  // Named internal events, brought out for the checker.
  logic req_sync_w;
  logic take_w;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (irq_req_async),
    .q_sync  (req_sync_w)
  );

  irq_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_s   (req_sync_w),
    .en_stb  (irq_en_stb),
    .dis_stb (irq_dis_stb),
    .ack     (irq_ack),
    .mask    (irq_masked),
    .take    (take_w)
  );

  irq_pcsel #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take_w),
    .pc_seq   (pc_seq),
    .pc_cur   (pc_cur),
    .pc_next  (pc_next),
    .pc_saved (pc_saved)
  );

  assign irq_alert = take_w;
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk #(
  parameter int              PC_W        = 30,
  parameter int              SYNC_STAGES = 2,
  parameter logic [PC_W-1:0] HANDLER_PC  = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_async,
  input logic            req_s,
  input logic            dis,
  input logic            ack,
  input logic            mask,
  input logic            alert,
  input logic [PC_W-1:0] pc_cur,
  input logic [PC_W-1:0] pc_next,
  input logic [PC_W-1:0] pc_saved
);
  generate
    if (SYNC_STAGES == 2) begin : g_sync2
      // R1: alert needs the raw request two edges back
      assert_sync_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        alert |-> $past(req_async, 2));
    end
  endgenerate

  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !alert);

  assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_s) |=> ack);

  assert_ack_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !alert);

  assert_alert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alert |=> !alert);

  assert_mask_on_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alert |=> (mask && ack));

  assert_dis_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> mask);

  assert_handler_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> (pc_next == HANDLER_PC));

  assert_save_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alert |=> (pc_saved == $past(pc_cur)));

  assert_save_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !alert |=> $stable(pc_saved));
endmodule

bind irq_front irq_front_chk #(
  .PC_W(PC_W), .SYNC_STAGES(SYNC_STAGES), .HANDLER_PC(HANDLER_PC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_async (irq_req_async),
  .req_s     (req_sync_w),
  .dis       (irq_dis_stb),
  .ack       (irq_ack),
  .mask      (irq_masked),
  .alert     (irq_alert),
  .pc_cur    (pc_cur),
  .pc_next   (pc_next),
  .pc_saved  (pc_saved)
);

// File: tb/sim_irq_front.sv
`timescale 1ns/1ps
module sim_irq_front;
  localparam int              PC_W = 30;
  localparam int              NS   = 2;
  localparam logic [PC_W-1:0] HPC  = PC_W'(32'h0000_0100);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, en = 1'b0, dis = 1'b0;
  logic [PC_W-1:0] pc_seq = '0, pc_cur = '0;
  logic ack, masked, alert;
  logic [PC_W-1:0] pc_next, pc_saved;

  int n_cmp = 0, n_bad = 0;
  int alerts_dut = 0, alerts_ref = 0;

  always #5 clk = ~clk;

  irq_front #(.PC_W(PC_W), .SYNC_STAGES(NS), .HANDLER_PC(HPC)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req_async(req), .irq_en_stb(en),
    .irq_dis_stb(dis), .pc_seq(pc_seq), .pc_cur(pc_cur),
    .irq_ack(ack), .irq_masked(masked), .irq_alert(alert),
    .pc_next(pc_next), .pc_saved(pc_saved));

  // Behavioural reference model
  bit              pipe[$];
  bit              m_ack, m_mask;
  logic [PC_W-1:0] m_saved;

  function automatic bit m_take();
    return pipe[$] && !m_mask && !m_ack;
  endfunction

  initial begin
    for (int i = 0; i < NS; i++) pipe.push_front(1'b0);
    m_ack = 0; m_mask = 1; m_saved = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) pipe[i] = 1'b0;
      m_ack = 0; m_mask = 1; m_saved = '0;
    end else begin
      bit tk;
      bit rs;
      tk = m_take();
      rs = pipe[$];
      if (tk) begin m_saved = pc_cur; alerts_ref++; end
      if (tk)       m_ack = 1;
      else if (!rs) m_ack = 0;
      if (tk || dis) m_mask = 1;
      else if (en)   m_mask = 0;
      pipe.push_front(req);
      void'(pipe.pop_back());
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit et;
      et = m_take();
      if (alert) alerts_dut++;
      chk("R1/R2/R4 alert", alert, et);
      chk("R3 ack", ack, m_ack);
      chk("R5/R6/R10 mask", masked, m_mask);
      chk("R8 pc_next", pc_next, et ? HPC : pc_seq);
      chk("R9 pc_saved", pc_saved, m_saved);
    end
  end

  task automatic step(bit r, bit e, bit d);
    @(negedge clk); #1;
    req = r; en = e; dis = d;
    pc_seq = PC_W'($urandom);
    pc_cur = PC_W'($urandom);
  endtask

  task automatic idle(int n, bit r);
    for (int i = 0; i < n; i++) step(r, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state
    chk("R7 mask", masked, 1);
    chk("R7 ack", ack, 0);
    chk("R7 alert", alert, 0);
    chk("R7 saved", pc_saved, 0);
    // R2: request held while masked
    idle(8, 1);
    chk("R2 no alert", alerts_dut, 0);
    idle(4, 0);
    step(0, 1, 0);               // R6 enable
    idle(2, 0);
    idle(8, 1);                  // R1 sync delay, R3 ack held
    idle(5, 0);
    step(0, 1, 0);
    // R3: enable while ack high and request high: no second take
    idle(6, 1);
    step(1, 1, 0);
    idle(6, 1);
    idle(5, 0);
    // R6: both strobes in one cycle
    step(0, 1, 1);
    idle(2, 0);
    chk("R6 both->mask", masked, 1);
    step(0, 1, 0);
    idle(2, 0);
    // R10: take coincides with enable strobe (req high at edge k -> alert after k+1)
    step(1, 0, 0);
    step(1, 0, 0);
    step(1, 1, 0);
    idle(4, 1);
    idle(4, 0);
    // take coincides with disable strobe
    step(0, 1, 0);
    step(1, 0, 0);
    step(1, 0, 0);
    step(1, 0, 1);
    idle(4, 0);
    // single-cycle request pulse
    step(0, 1, 0);
    step(1, 0, 0);
    idle(8, 0);
    // mixed random traffic
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0, $urandom_range(0, 11) == 0);
    idle(6, 0);
    chk("R4 alert count", alerts_dut, alerts_ref);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule